// File: doc/BRIEF.md
# Sled Motor Home-In Controller

This block turns a one-byte sled command into drive enables for the sled motor of an optical disc mechanism. A command byte is taken on a strobe. The top bit selects an automatic homing run. When that bit is clear, a two-bit field selects one of four plain modes: off, servo hold, forward travel or reverse travel.

In a homing run the sled is driven in reverse until the inner limit switch closes. It is then driven forward for a programmed number of timebase ticks and stops. A sense output follows the progress of the run, and a one-cycle done pulse marks its end. The limit switch is asynchronous, so it passes through a synchroniser whose depth is a parameter. The forward tick count is sampled from a 16-bit input when the command is taken.

An abort input returns the block to off from any state. Motor PWM and the analog drive sit outside the block.

Top module: `sled_home_ctrl`

## Requirements
- R1: After reset `drv_fwd`, `drv_rev`, `servo_en`, `sense` and `done` are all low.
- R2: A taken command with bit 7 = 0 selects a mode from bits 6:5. The codes are 00 off (all drives low), 01 hold (`servo_en` high), 10 forward (`drv_fwd` high) and 11 reverse (`drv_rev` high). The new mode shows on the outputs in the cycle after the strobe edge.
- R3: A taken command with bit 7 = 1 starts a homing run with `drv_rev` high in the cycle after the strobe. Bits 6:5 have no effect on this.
- R4: In a homing run, reverse drive continues until the limit switch is seen high after SYNC_STAGES clock stages. On the edge where it is seen, the block switches to forward drive.
- R5: Forward drive in a homing run lasts until the home tick count (sampled with the command) has been reached in `tick` pulses. The block then goes off, and `done` is high for exactly one cycle.
- R6: When the sampled home tick count is zero, the run ends on the edge where the limit is seen. `done` pulses once and there is no forward drive.
- R7: `sense` is low while a homing run drives in reverse. It goes high when the limit is seen and stays high until the next taken command or an abort.
- R8: A command whose reserved bits 4:0 are not all zero is not taken, and the current state and outputs carry on unchanged.
- R9: `abort` forces all outputs low on the next edge. It takes priority over a command strobe in the same cycle.
- R10: `drv_fwd` and `drv_rev` are never high together. While `done` is high, neither drive is high.
- R11: A taken command received during a homing run ends the run at once and applies the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_byte | input | 8 | Command byte: home bit 7, mode bits 6:5, reserved bits 4:0 |
| home_ticks | input | TIME_W (16) | Forward tick count for homing, sampled with the command |
| abort | input | 1 | Return to off |
| limit_sw | input | 1 | Inner limit switch, asynchronous, high at limit |
| tick | input | 1 | Timebase pulse, one cycle |
| drv_fwd | output | 1 | Forward drive enable |
| drv_rev | output | 1 | Reverse drive enable |
| servo_en | output | 1 | Sled servo hold enable |
| sense | output | 1 | Homing progress: high once the limit has been reached |
| done | output | 1 | One-cycle pulse at the end of a homing run |

## Verification
Each drive output is a direct decode of the state register, so a wrong state shows on `drv_fwd`, `drv_rev` or `servo_en` in the very next cycle. A wrong forward counter shows up as a `done` pulse that comes early or late, relative to the count of `tick` pulses the bench has issued. A wrong synchroniser depth moves the reverse-to-forward switch off the expected edge by at least one cycle. The reference model predicts every output on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/sled_pkg.sv
package sled_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_HOLD = 3'd1,
        ST_FWD  = 3'd2,
        ST_REV  = 3'd3,
        ST_HREV = 3'd4,
        ST_HFWD = 3'd5
    } sled_st_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_HOLD = 2'b01,
        MD_FWD  = 2'b10,
        MD_REV  = 2'b11
    } sled_md_e;

    typedef struct packed {
        logic     home;
        sled_md_e mode;
        logic [4:0] rsvd;
    } sled_cmd_t;

    typedef struct packed {
        logic fwd;
        logic rev;
        logic hold;
    } sled_drv_t;

    function automatic sled_st_e mode_state(input sled_md_e m);
        case (m)
            MD_HOLD: return ST_HOLD;
            MD_FWD:  return ST_FWD;
            MD_REV:  return ST_REV;
            default: return ST_OFF;
        endcase
    endfunction

    function automatic sled_drv_t drive_of(input sled_st_e s);
        sled_drv_t d;
        d.fwd  = (s == ST_FWD) || (s == ST_HFWD);
        d.rev  = (s == ST_REV) || (s == ST_HREV);
        d.hold = (s == ST_HOLD);
        return d;
    endfunction

endpackage

// File: rtl/sled_cmd_decode.sv
module sled_cmd_decode
    import sled_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_byte,
    output logic              accept,
    output sled_st_e          req_st
);
    sled_cmd_t c;

    always_comb begin
        c      = sled_cmd_t'(cmd_byte);
        accept = cmd_valid && (c.rsvd == '0);
        // home bit is examined before the mode field
        if (c.home) req_st = ST_HREV;
        else        req_st = mode_state(c.mode);
    end
endmodule

// File: rtl/sled_limit_sync.sv
module sled_limit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/sled_home_timer.sv
module sled_home_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                               cnt_q <= '0;
        else if (load)                         cnt_q <= load_val;
        else if (run && tick && cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    assign expire = run && tick && (cnt_q == ONE);
endmodule

// File: rtl/sled_home_ctrl.sv
module sled_home_ctrl
    import sled_pkg::*;
#(
    parameter int TIME_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic [TIME_W-1:0] home_ticks,
    input  logic              abort,
    input  logic              limit_sw,
    input  logic              tick,
    output logic              drv_fwd,
    output logic              drv_rev,
    output logic              servo_en,
    output logic              sense,
    output logic              done
);
    sled_st_e          st_q, st_d, req_st;
    logic              accept, lim_s, expire, tmr_load;
    logic              sense_q, sense_d, done_q, done_d;
    logic [TIME_W-1:0] ticks_q;
    sled_drv_t         drv;

    sled_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .accept    (accept),
        .req_st    (req_st)
    );

    sled_limit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (limit_sw),
        .dout (lim_s)
    );

    sled_home_timer #(.W(TIME_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (ticks_q),
        .run      (st_q == ST_HFWD),
        .tick     (tick),
        .expire   (expire)
    );

    always_comb begin
        st_d     = st_q;
        sense_d  = sense_q;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        if (abort) begin
            st_d    = ST_OFF;
            sense_d = 1'b0;
        end else if (accept) begin
            st_d    = req_st;
            sense_d = 1'b0;
        end else begin
            case (st_q)
                ST_HREV: if (lim_s) begin
                    sense_d = 1'b1;
                    if (ticks_q == '0) begin
                        st_d   = ST_OFF;
                        done_d = 1'b1;
                    end else begin
                        st_d     = ST_HFWD;
                        tmr_load = 1'b1;
                    end
                end
                ST_HFWD: if (expire) begin
                    st_d   = ST_OFF;
                    done_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            sense_q <= 1'b0;
            done_q  <= 1'b0;
            ticks_q <= '0;
        end else begin
            st_q    <= st_d;
            sense_q <= sense_d;
            done_q  <= done_d;
            if (accept && !abort) ticks_q <= home_ticks;
        end
    end

    assign drv      = drive_of(st_q);
    assign drv_fwd  = drv.fwd;
    assign drv_rev  = drv.rev;
    assign servo_en = drv.hold;
    assign sense    = sense_q;
    assign done     = done_q;
endmodule

// File: rtl/sled_home_ctrl_chk.sv
module sled_home_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       abort,
    input logic       drv_fwd,
    input logic       drv_rev,
    input logic       servo_en,
    input logic       sense,
    input logic       done
);
    // R10
    drive_mutex_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv_fwd && drv_rev));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!drv_fwd && !drv_rev));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_after_drive_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(drv_fwd || drv_rev));

    // R9
    abort_off_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!drv_fwd && !drv_rev && !servo_en && !sense && !done));

    // R7
    rev_sense_low_chk: assert property (@(posedge clk) disable iff (rst)
        drv_rev |-> !sense);

    // R3
    home_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !abort && cmd_byte[7] && cmd_byte[4:0] == 5'd0)
        |=> (drv_rev && !sense));

    // R2
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !abort && cmd_byte == 8'h20)
        |=> (servo_en && !drv_fwd && !drv_rev));
endmodule

bind sled_home_ctrl sled_home_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .abort     (abort),
    .drv_fwd   (drv_fwd),
    .drv_rev   (drv_rev),
    .servo_en  (servo_en),
    .sense     (sense),
    .done      (done)
);

// File: tb/sled_home_ctrl_tb_top.sv
`timescale 1ns/100ps
module sled_home_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [15:0] home_ticks = 16'd0;
    logic        abort = 1'b0;
    logic        limit_sw = 1'b0;
    logic        tick = 1'b0;
    logic        drv_fwd, drv_rev, servo_en, sense, done;

    int checks = 0;
    int errors = 0;
    int cyc_n = 0;
    int tdiv = 0;
    int done_cnt = 0;

    // reference model state: 0 off,1 hold,2 fwd,3 rev,4 home-rev,5 home-fwd
    int m_st = 0;
    int m_cnt = 0;
    int m_h = 0;
    bit m_sense = 0;
    bit m_done = 0;
    bit m_l0 = 0;
    bit m_l1 = 0;

    always #2.5 clk = ~clk;

    sled_home_ctrl dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .home_ticks(home_ticks), .abort(abort), .limit_sw(limit_sw), .tick(tick),
        .drv_fwd(drv_fwd), .drv_rev(drv_rev), .servo_en(servo_en),
        .sense(sense), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin tdiv = 0; tick = 1'b0; end
        else begin tdiv = (tdiv + 1) % 3; tick = (tdiv == 0); end
    end

    always @(posedge clk) begin
        bit lsync;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_h = 0; m_sense = 0; m_done = 0; m_l0 = 0; m_l1 = 0;
        end else begin
            lsync  = m_l1;
            m_done = 0;
            if (abort) begin
                m_st = 0; m_sense = 0;
            end else if (cmd_valid && cmd_byte[4:0] == 5'd0) begin
                m_sense = 0;
                m_h = home_ticks;
                m_st = cmd_byte[7] ? 4 : cmd_byte[6:5];
            end else if (m_st == 4 && lsync) begin
                m_sense = 1;
                if (m_h == 0) begin m_st = 0; m_done = 1; end
                else begin m_st = 5; m_cnt = m_h; end
            end else if (m_st == 5 && tick) begin
                if (m_cnt == 1) begin m_st = 0; m_done = 1; end
                else m_cnt = m_cnt - 1;
            end
            m_l1 = m_l0;
            m_l0 = limit_sw;
        end
        #1;
        if (!rst) begin
            chk(drv_fwd == (m_st == 2 || m_st == 5), "R2 R4 R5 drv_fwd", drv_fwd, (m_st == 2 || m_st == 5));
            chk(drv_rev == (m_st == 3 || m_st == 4), "R3 R4 drv_rev", drv_rev, (m_st == 3 || m_st == 4));
            chk(servo_en == (m_st == 1), "R2 servo_en", servo_en, (m_st == 1));
            chk(sense == m_sense, "R7 sense", sense, m_sense);
            chk(done == m_done, "R5 R6 done", done, m_done);
            chk(!(drv_fwd && drv_rev), "R10 drive overlap", drv_fwd & drv_rev, 0);
            if (done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n == 50000) begin
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=<50000", cyc_n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int t);
        @(negedge clk);
        cmd_byte = b; home_ticks = 16'(t); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    initial begin
        wait_cyc(4);
        #1;
        // R1 reset state
        chk({drv_fwd, drv_rev, servo_en, sense, done} == 5'b0, "R1 reset outputs",
            {drv_fwd, drv_rev, servo_en, sense, done}, 0);
        @(negedge clk); rst = 1'b0;
        wait_cyc(3);

        // R2 plain modes
        send(8'h20, 0); wait_cyc(4);
        send(8'h40, 0); wait_cyc(4);
        send(8'h60, 0); wait_cyc(4);
        send(8'h00, 0); wait_cyc(3);

        // R8 reserved bits set: command not taken
        send(8'h41, 0); wait_cyc(2);
        chk(!drv_fwd, "R8 reserved command ignored", drv_fwd, 0);
        send(8'h20, 0); send(8'h62, 0); wait_cyc(2);
        chk(servo_en, "R8 hold kept after bad command", servo_en, 1);

        // R3 R4 R5 homing with 4 forward ticks; mode field must not matter
        done_cnt = 0;
        send(8'hC0, 4); wait_cyc(8);
        limit_sw = 1'b1; wait_cyc(5); limit_sw = 1'b0;
        wait_cyc(25);
        chk(done_cnt == 1, "R5 one done pulse", done_cnt, 1);
        chk(sense, "R7 sense held after run", sense, 1);

        // R6 zero tick count
        done_cnt = 0;
        send(8'hE0, 0); wait_cyc(5);
        limit_sw = 1'b1; wait_cyc(6); limit_sw = 1'b0;
        wait_cyc(4);
        chk(done_cnt == 1, "R6 immediate done", done_cnt, 1);

        // R4 limit already closed at start; count of 1
        limit_sw = 1'b1;
        send(8'h80, 1); wait_cyc(10);
        limit_sw = 1'b0; wait_cyc(3);

        // R9 abort during reverse and during forward
        send(8'h80, 50); wait_cyc(4);
        pulse_abort(); wait_cyc(1);
        chk(!drv_rev && !sense, "R9 abort in reverse", drv_rev, 0);
        send(8'h80, 50); wait_cyc(3);
        limit_sw = 1'b1; wait_cyc(5); limit_sw = 1'b0; wait_cyc(4);
        pulse_abort(); wait_cyc(1);
        chk(!drv_fwd && !sense, "R9 abort in forward", drv_fwd, 0);

        // R9 abort wins over simultaneous command
        @(negedge clk); cmd_byte = 8'h40; cmd_valid = 1'b1; abort = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; abort = 1'b0;
        chk(!drv_fwd, "R9 abort priority", drv_fwd, 0);

        // R11 override of a homing run by a plain command
        send(8'h80, 6); wait_cyc(4);
        send(8'h40, 0); wait_cyc(1);
        chk(drv_fwd && !sense, "R11 override in reverse", drv_fwd, 1);
        send(8'h80, 30); wait_cyc(2);
        limit_sw = 1'b1; wait_cyc(5); limit_sw = 1'b0; wait_cyc(2);
        send(8'h20, 0); wait_cyc(1);
        chk(servo_en && !drv_fwd, "R11 override in forward", servo_en, 1);
        send(8'h00, 0); wait_cyc(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule